// File: doc/BRIEF.md
# Serial Readback and Daisy-Chain Data Output

This block drives the serial data output pin of a 16-bit-frame SPI slave. One pin serves two purposes, chosen by a mode input. In readback mode the pin shifts out a dedicated output register. That register is loaded with a channel value when a read command frame closes. In the two daisy-chain modes the pin repeats the bits of the input shift register, delayed by one frame, so that the next device in a chain receives them. The two daisy-chain modes differ only in the serial clock edge that updates the pin.

All inputs are sampled on a fast system clock. Chip select and serial clock edges are found by comparing each input with its registered copy. An output-enable signal travels alongside the data. Readback mode releases the pin whenever chip select is high. Daisy-chain mode always drives the pin and holds it high between frames, so the downstream input never floats.

Top module: `serial_dout_port`

## Requirements
- R1: After reset the readback register holds no valid data, the daisy-chain output is 1 and the bit counter is empty.
- R2: While cs_n is low, sdi is captured on each rising sclk edge, MSB first. The command of a frame is the last 16 bits captured. A frame that ends with fewer than 16 bits carries no command.
- R3: A frame is a read command when bits 15:12 equal the RD_OPCODE parameter (default 4'hA). Bits 10:8 select the channel, and bit 11 is ignored. The chosen 16-bit slice of rd_vals (channel c at bits 16c+15:16c) is loaded when cs_n rises. Any other opcode loads nothing.
- R4: In the frame after a read command, the readback output presents the loaded value MSB first. The MSB appears from the start of the frame, each falling sclk edge moves to the next bit, and zeros follow the 16th bit.
- R5: Readback data lasts one frame only. A frame after a non-read frame, or after a short frame, reads as all zeros.
- R6: In readback mode sdo_oe is 0 while cs_n is high and 1 while cs_n is low.
- R7: In daisy-chain mode sdo_oe is always 1, and sdo is 1 while cs_n is high.
- R8: In daisy-chain mode sdo stays 1 until 16 bits of the current frame have been captured.
- R9: In mode 2'b01 (falling-edge daisy chain), the falling sclk edge after the k-th rising edge (k ≥ 16) sets sdo to bit k-15 of the frame, counting from 1 for the first bit.
- R10: In mode 2'b10 (rising-edge daisy chain), the k-th rising sclk edge (k ≥ 17) sets sdo to bit k-16 of the frame.
- R11: Mode 2'b00 and mode 2'b11 both select readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| mode | input | 2 | 00/11 readback, 01 falling-edge daisy chain, 10 rising-edge daisy chain |
| rd_vals | input | NUM_CH*FRAME_W | Channel values available to a read command |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means high impedance |

## Verification
Readback is tried with several patterns: read frames for different channels, a read frame with bit 11 set, and a frame carrying the wrong opcode. It is also tried with a 12-bit frame and a 20-bit frame whose last 16 bits form a read. These separate correct opcode and channel decoding from decoding that uses the first 16 bits or accepts short frames. Repeating a data frame after a readback frame shows that valid data lasts one frame only. The daisy-chain modes are driven with 24-bit frames. There the one-edge difference between the falling-edge and rising-edge variants shows up as a shift of one position in the collected stream. A behavioural model compares sdo and sdo_oe on every system clock.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  typedef enum logic [1:0] {
    SDO_RB      = 2'b00,
    SDO_DC_FALL = 2'b01,
    SDO_DC_RISE = 2'b10,
    SDO_RB_ALT  = 2'b11
  } sdo_mode_e;

  // Daisy-chain variants drive the pin permanently.
  function automatic logic mode_is_daisy(input logic [1:0] m);
    return (m == SDO_DC_FALL) || (m == SDO_DC_RISE);
  endfunction

  // Selects which detected sclk edge advances the daisy-chain output.
  function automatic logic daisy_step(input logic [1:0] m, input logic rise, input logic fall);
    return ((m == SDO_DC_FALL) && fall) || ((m == SDO_DC_RISE) && rise);
  endfunction
endpackage

// File: rtl/spi_sclk_edges.sv
module spi_sclk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_end
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign sclk_rise = ~cs_n & sclk & ~sclk_q;
  assign sclk_fall = ~cs_n & ~sclk & sclk_q;
  assign frame_end = cs_n & ~cs_q;
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk_rise,
  input  logic               sdi,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      cnt   <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      frame <= {frame[FRAME_W-2:0], sdi};
      if (!full) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(FRAME_W));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !cs_n |=> full);
  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) && cs_n |-> cnt == '0);
endmodule

// File: rtl/spi_rb_reg.sv
module spi_rb_reg #(
  parameter int             FRAME_W   = 16,
  parameter int             NUM_CH    = 8,
  parameter int             OP_W      = 4,
  parameter logic [OP_W-1:0] RD_OPCODE = 4'hA
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_end,
  input  logic                      sclk_fall,
  input  logic [FRAME_W-1:0]        frame,
  input  logic                      full,
  input  logic [NUM_CH*FRAME_W-1:0] rd_vals,
  output logic                      rb_bit,
  output logic                      rb_valid
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_LSB = FRAME_W - 2 * OP_W;

  logic [FRAME_W-1:0] out_q;
  logic               read_hit;
  logic [CH_W-1:0]    ch_idx;

  function automatic logic [FRAME_W-1:0] pick_chan(input logic [NUM_CH*FRAME_W-1:0] vals,
                                                   input logic [CH_W-1:0] idx);
    logic [FRAME_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (idx == CH_W'(i)) r = vals[i*FRAME_W +: FRAME_W];
    return r;
  endfunction

  assign read_hit = full && (frame[FRAME_W-1 -: OP_W] == RD_OPCODE);
  assign ch_idx   = frame[CH_LSB +: CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      rb_valid <= 1'b0;
    end else if (frame_end) begin
      rb_valid <= read_hit;
      if (read_hit) out_q <= pick_chan(rd_vals, ch_idx);
    end else if (sclk_fall) begin
      out_q <= {out_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign rb_bit = rb_valid & out_q[FRAME_W-1];

  // R3
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_valid) |-> $past(full) && $past(frame_end));
  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !read_hit |=> !rb_valid);
endmodule

// File: rtl/spi_dc_out.sv
module spi_dc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic step,
  input  logic full,
  input  logic oldest_bit,
  output logic dc_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dc_bit <= 1'b1;
    else if (cs_n)   dc_bit <= 1'b1;
    else if (step)   dc_bit <= full ? oldest_bit : 1'b1;
  end

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> dc_bit);
  // R8
  early_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !full && !cs_n |=> dc_bit);
endmodule

// File: rtl/serial_dout_port.sv
module serial_dout_port
  import sdo_pkg::*;
#(
  parameter int              FRAME_W   = 16,
  parameter int              NUM_CH    = 8,
  parameter int              OP_W      = 4,
  parameter logic [OP_W-1:0] RD_OPCODE = 4'hA
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic [1:0]                mode,
  input  logic [NUM_CH*FRAME_W-1:0] rd_vals,
  output logic                      sdo,
  output logic                      sdo_oe
);
  logic               sclk_rise;
  logic               sclk_fall;
  logic               frame_end;
  logic [FRAME_W-1:0] frame;
  logic               full;
  logic               rb_bit;
  logic               rb_valid;
  logic               dc_bit;
  logic               dc_step;
  logic               daisy;

  spi_sclk_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .frame_end (frame_end)
  );

  spi_rx_frame #(.FRAME_W(FRAME_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sdi       (sdi),
    .frame     (frame),
    .full      (full)
  );

  spi_rb_reg #(
    .FRAME_W   (FRAME_W),
    .NUM_CH    (NUM_CH),
    .OP_W      (OP_W),
    .RD_OPCODE (RD_OPCODE)
  ) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .sclk_fall (sclk_fall),
    .frame     (frame),
    .full      (full),
    .rd_vals   (rd_vals),
    .rb_bit    (rb_bit),
    .rb_valid  (rb_valid)
  );

  assign daisy   = mode_is_daisy(mode);
  assign dc_step = daisy_step(mode, sclk_rise, sclk_fall);

  spi_dc_out u_dc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .step       (dc_step),
    .full       (full),
    .oldest_bit (frame[FRAME_W-1]),
    .dc_bit     (dc_bit)
  );

  assign sdo    = daisy ? dc_bit : rb_bit;
  assign sdo_oe = daisy | ~cs_n;

  // R4
  rb_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !daisy && !rb_valid |-> !sdo);
  // R6
  rb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !daisy && $past(cs_n) && cs_n |-> !sdo_oe);
endmodule

// File: tb/serial_dout_port_tb.sv
module serial_dout_port_tb;
  localparam int FW = 16;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [NC*FW-1:0] rd_vals;
  logic sdo, sdo_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serial_dout_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .mode(mode), .rd_vals(rd_vals), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [15:0] chan_val(input int c);
    return 16'hC3A5 ^ (16'(c) * 16'h1111);
  endfunction

  // behavioural reference model
  logic m_sclk_q, m_cs_q, m_valid, m_dc;
  bit   m_bits[$];
  bit   m_rq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sclk_q = 0; m_cs_q = 1; m_valid = 0; m_dc = 1;
      m_bits.delete(); m_rq.delete();
      for (int i = 0; i < 16; i++) m_rq.push_back(0);
    end else begin
      bit rise, fall, fend;
      int n;
      rise = !cs_n && sclk && !m_sclk_q;
      fall = !cs_n && !sclk && m_sclk_q;
      fend = cs_n && !m_cs_q;
      n = m_bits.size();
      if (fend) begin
        int op, ch;
        op = 0; ch = 0;
        if (n >= 16) begin
          for (int i = 0; i < 4; i++) op = op * 2 + m_bits[n-16+i];
          for (int i = 5; i < 8; i++) ch = ch * 2 + m_bits[n-16+i];
        end
        if (n >= 16 && op == 10) begin
          logic [15:0] v;
          v = chan_val(ch);
          m_valid = 1;
          m_rq.delete();
          for (int i = 15; i >= 0; i--) m_rq.push_back(v[i]);
        end else m_valid = 0;
      end else if (fall) begin
        void'(m_rq.pop_front());
        m_rq.push_back(0);
      end
      if (cs_n) m_dc = 1;
      else if ((mode == 2'b01 && fall) || (mode == 2'b10 && rise))
        m_dc = (n >= 16) ? m_bits[n-16] : 1;
      if (cs_n) m_bits.delete();
      else if (rise) m_bits.push_back(sdi);
      m_sclk_q = sclk; m_cs_q = cs_n;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit dz, e_oe, e_sdo;
      string tag;
      dz = (mode == 2'b01 || mode == 2'b10);
      e_oe  = dz ? 1'b1 : !cs_n;
      e_sdo = dz ? m_dc : (m_valid ? m_rq[0] : 1'b0);
      if (!dz) tag = cs_n ? "R6" : "R4";
      else if (cs_n) tag = "R7";
      else if (m_bits.size() < 16) tag = "R8";
      else tag = (mode == 2'b01) ? "R9" : "R10";
      checks++;
      if (sdo_oe !== e_oe || (e_oe && sdo !== e_sdo)) begin
        errors++;
        $display("FAIL %s model: oe=%b sdo=%b expected oe=%b sdo=%b", tag, sdo_oe, sdo, e_oe, e_sdo);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // got[n-1-i] holds sdo sampled just before the i-th rising sclk edge
  task automatic send_frame(input logic [31:0] d, input int n, output logic [31:0] got);
    got = '0;
    cs_n = 0; step(3);
    for (int i = 0; i < n; i++) begin
      sclk = 0; sdi = d[n-1-i]; step(3);
      got[n-1-i] = sdo;
      sclk = 1; step(3);
    end
    sclk = 0; step(3);
    cs_n = 1; step(4);
  endtask

  logic [31:0] g;

  initial begin
    for (int c = 0; c < NC; c++) rd_vals[c*FW +: FW] = chan_val(c);
    step(3);
    rst_n = 1; step(2);
    check("R1 R6 oe idle readback", {31'd0, sdo_oe}, 32'd0);
    mode = 2'b01; step(1);
    check("R1 R7 daisy oe/sdo idle", {30'd0, sdo_oe, sdo}, 32'd3);
    mode = 2'b00; step(1);
    send_frame(32'h0000, 16, g);
    check("R1 no data after reset", g & 32'hFFFF, 32'd0);

    send_frame(32'hA500, 16, g);
    send_frame(32'h1234, 16, g);
    check("R3 R4 read ch5", g & 32'hFFFF, {16'd0, chan_val(5)});
    send_frame(32'h0000, 16, g);
    check("R5 one frame only", g & 32'hFFFF, 32'd0);

    send_frame(32'hA30, 12, g);
    send_frame(32'h0000, 16, g);
    check("R2 short frame ignored", g & 32'hFFFF, 32'd0);

    send_frame(32'hFA200, 20, g);
    send_frame(32'h0000, 16, g);
    check("R2 last 16 bits decoded ch2", g & 32'hFFFF, {16'd0, chan_val(2)});

    send_frame(32'hAB00, 16, g);
    send_frame(32'h0000, 16, g);
    check("R3 bit11 ignored ch3", g & 32'hFFFF, {16'd0, chan_val(3)});

    send_frame(32'h5500, 16, g);
    send_frame(32'h0000, 16, g);
    check("R3 wrong opcode", g & 32'hFFFF, 32'd0);

    mode = 2'b11; step(1);
    send_frame(32'hA700, 16, g);
    send_frame(32'h0000, 16, g);
    check("R11 mode 3 readback ch7", g & 32'hFFFF, {16'd0, chan_val(7)});

    // daisy, falling edge: before rise k, sdo = bit k-16 (k>=17) else 1
    mode = 2'b01; step(1);
    send_frame(32'h00B6_5F3C, 24, g);
    begin
      logic [31:0] e;
      logic [23:0] d;
      d = 24'hB65F3C; e = '0;
      for (int k = 1; k <= 24; k++)
        e[24-k] = (k >= 17) ? d[24-(k-16)] : 1'b1;
      check("R8 R9 falling-edge daisy stream", g, e);
    end
    check("R7 idle high after frame", {31'd0, sdo}, 32'd1);

    // daisy, rising edge: before rise k, sdo = bit k-17 (k>=18) else 1
    mode = 2'b10; step(1);
    send_frame(32'h00B6_5F3C, 24, g);
    begin
      logic [31:0] e;
      logic [23:0] d;
      d = 24'hB65F3C; e = '0;
      for (int k = 1; k <= 24; k++)
        e[24-k] = (k >= 18) ? d[24-(k-17)] : 1'b1;
      check("R8 R10 rising-edge daisy stream", g, e);
    end
    check("R7 oe daisy", {31'd0, sdo_oe}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule